// File: doc/BRIEF.md
# Serial Two-Number Combination Lock Controller

A clocked controller for a lock opened by entering two 2-bit numbers, one after the other. The user sets a 2-bit switch code and confirms it with a one-cycle enter strobe. If both numbers are right, the open output rises. A wrong number at either step raises an error output, and that output stays high until the restart button is pressed. Idle cycles between strobes are allowed and do not change the state.

Two comparator stages turn the switch code into a match flag for each combination number, so the combination can be changed without touching the sequencing logic. A Mealy next-state and output block reads those flags, the restart and enter inputs, and the present state. A 3-bit state register with a shared asynchronous clear holds the state. Both combination numbers are module parameters, and elaboration rejects a pair of equal numbers.

Top module: `combo_lock`

## Requirements
- R1: While rst_ni is low, the state register is cleared to the start state (encoding 3'b000). With restart_i and enter_i low, open_o and error_o read 0.
- R2: In the start state, an enter strobe with code_i equal to parameter FIRST_NUM moves the lock to the first-accepted state. Neither output is asserted in that cycle.
- R3: In any cycle with enter_i low and restart_i low, the state does not change, whatever code_i holds.
- R4: In the first-accepted state, an enter strobe with code_i equal to SECOND_NUM raises open_o in that same cycle. open_o then stays 1 on every later cycle until restart_i or rst_ni.
- R5: In the start state, an enter strobe with code_i not equal to FIRST_NUM raises error_o in that same cycle. error_o then stays 1 on every later cycle until restart_i or rst_ni.
- R6: In the first-accepted state, an enter strobe with code_i not equal to SECOND_NUM raises error_o in that same cycle. error_o then stays 1 until restart_i or rst_ni.
- R7: When restart_i is high, open_o and error_o are 0 in that cycle and the next state is the start state, whatever the present state is. restart_i takes priority over enter_i.
- R8: Enter strobes in the open state or the error state have no effect.
- R9: open_o and error_o are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous clear of the state register |
| restart_i | input | 1 | Synchronous restart button, returns the lock to the start state |
| enter_i | input | 1 | One-cycle strobe that confirms the code on code_i |
| code_i | input | CODE_W | Switch code being entered |
| open_o | output | 1 | Unlock output (Mealy) |
| error_o | output | 1 | Sticky wrong-entry output (Mealy) |

## Verification
The bench builds the lock with FIRST_NUM = 2 and SECOND_NUM = 0, not the defaults. This places one combination number on the all-zero code, so a design that confuses a zero code with no match, or that swaps the two comparators, gives wrong outputs. Because the switch input has only four values, the random code stream covers every match and mismatch at both steps. The random stream also mixes restarts and idle gaps at every state, including strobes that arrive while the lock is already open or in error.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;
  localparam int unsigned STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    LK_IDLE  = 3'b000,
    LK_GOT1  = 3'b001,
    LK_OPEN  = 3'b010,
    LK_FAIL  = 3'b011
  } lk_state_e;
endpackage

// File: rtl/combo_match.sv
module combo_match #(
  parameter int unsigned CODE_W = 2,
  parameter logic [CODE_W-1:0] NUM = '0
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              hit_o
);
  assign hit_o = (code_i == NUM);
endmodule

// File: rtl/combo_state_reg.sv
module combo_state_reg #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[b] <= 1'b0;
      else         q_o[b] <= d_i[b];
    end
  end
endmodule

// File: rtl/combo_next.sv
module combo_next
  import combo_lock_pkg::*;
(
  input  logic               restart_i,
  input  logic               enter_i,
  input  logic               hit1_i,
  input  logic               hit2_i,
  input  logic [STATE_W-1:0] cur_i,
  output logic [STATE_W-1:0] nxt_o,
  output logic               open_o,
  output logic               error_o
);
  lk_state_e nxt;

  always_comb begin
    nxt     = LK_IDLE;
    open_o  = 1'b0;
    error_o = 1'b0;
    if (!restart_i) begin
      case (cur_i)
        LK_IDLE: begin
          if (!enter_i)     nxt = LK_IDLE;
          else if (hit1_i)  nxt = LK_GOT1;
          else begin
            nxt     = LK_FAIL;
            error_o = 1'b1;
          end
        end
        LK_GOT1: begin
          if (!enter_i) nxt = LK_GOT1;
          else if (hit2_i) begin
            nxt    = LK_OPEN;
            open_o = 1'b1;
          end else begin
            nxt     = LK_FAIL;
            error_o = 1'b1;
          end
        end
        LK_OPEN: begin
          nxt    = LK_OPEN;
          open_o = 1'b1;
        end
        LK_FAIL: begin
          nxt     = LK_FAIL;
          error_o = 1'b1;
        end
        default: nxt = LK_IDLE; // unused codes fall back to start
      endcase
    end
  end

  assign nxt_o = nxt;
endmodule

// File: rtl/combo_lock.sv
module combo_lock
  import combo_lock_pkg::*;
#(
  parameter int unsigned CODE_W = 2,
  parameter logic [CODE_W-1:0] FIRST_NUM  = 2'd1,
  parameter logic [CODE_W-1:0] SECOND_NUM = 2'd3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              enter_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              open_o,
  output logic              error_o
);
  if (FIRST_NUM == SECOND_NUM) begin : g_bad_combo
    $error("combo_lock: FIRST_NUM and SECOND_NUM must differ");
  end

  logic               hit1, hit2;
  logic [STATE_W-1:0] state_q, state_d;

  combo_match #(.CODE_W(CODE_W), .NUM(FIRST_NUM)) u_match1 (
    .code_i (code_i),
    .hit_o  (hit1)
  );

  combo_match #(.CODE_W(CODE_W), .NUM(SECOND_NUM)) u_match2 (
    .code_i (code_i),
    .hit_o  (hit2)
  );

  combo_next u_next (
    .restart_i (restart_i),
    .enter_i   (enter_i),
    .hit1_i    (hit1),
    .hit2_i    (hit2),
    .cur_i     (state_q),
    .nxt_o     (state_d),
    .open_o    (open_o),
    .error_o   (error_o)
  );

  combo_state_reg #(.WIDTH(STATE_W)) u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (state_d),
    .q_o    (state_q)
  );
endmodule

// File: rtl/combo_lock_chk.sv
module combo_lock_chk
  import combo_lock_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               restart_i,
  input logic               enter_i,
  input logic               hit1,
  input logic               hit2,
  input logic [STATE_W-1:0] state_q,
  input logic               open_o,
  input logic               error_o
);
  AST_RESTART_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |-> (!open_o && !error_o)); // R7

  AST_RESTART_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (state_q == LK_IDLE)); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !enter_i) |=> $stable(state_q)); // R3

  AST_OPEN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && !restart_i) |=> (open_o || restart_i)); // R4

  AST_ERROR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_o && !restart_i) |=> (error_o || restart_i)); // R5

  AST_NO_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(open_o && error_o)); // R9

  AST_MATCH_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hit1, hit2})); // R2

  AST_FIRST_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LK_IDLE && enter_i && hit1 && !restart_i) |=> (state_q == LK_GOT1)); // R2
endmodule

bind combo_lock combo_lock_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .restart_i (restart_i),
  .enter_i   (enter_i),
  .hit1      (hit1),
  .hit2      (hit2),
  .state_q   (state_q),
  .open_o    (open_o),
  .error_o   (error_o)
);

// File: tb/combo_lock_test.sv
`timescale 1ns/1ps
module combo_lock_test;
  localparam logic [1:0] N1 = 2'd2;
  localparam logic [1:0] N2 = 2'd0;
  localparam int S_IDLE = 0, S_GOT1 = 1, S_OPEN = 2, S_FAIL = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       restart = 1'b0;
  logic       enter = 1'b0;
  logic [1:0] code = 2'd0;
  logic       open_w, error_w;

  int checks = 0;
  int errors = 0;
  int mstate = S_IDLE;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  combo_lock #(.CODE_W(2), .FIRST_NUM(N1), .SECOND_NUM(N2)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .restart_i (restart),
    .enter_i   (enter),
    .code_i    (code),
    .open_o    (open_w),
    .error_o   (error_w)
  );

  // expected {open, error} for model state and inputs
  function automatic logic [1:0] exp_out(int st, bit r, bit en, logic [1:0] c);
    if (r) return 2'b00;
    if (st == S_OPEN) return 2'b10;
    if (st == S_FAIL) return 2'b01;
    if (!en) return 2'b00;
    if (st == S_IDLE) return (c == N1) ? 2'b00 : 2'b01;
    return (c == N2) ? 2'b10 : 2'b01;
  endfunction

  function automatic int exp_next(int st, bit r, bit en, logic [1:0] c);
    if (r) return S_IDLE;
    if (!en || st == S_OPEN || st == S_FAIL) return st;
    if (st == S_IDLE) return (c == N1) ? S_GOT1 : S_FAIL;
    return (c == N2) ? S_OPEN : S_FAIL;
  endfunction

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {open,error} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check before posedge, advance model
  task automatic step(string tag, bit r, bit en, logic [1:0] c);
    @(negedge clk);
    restart = r; enter = en; code = c;
    #1;
    check(tag, {open_w, error_w}, exp_out(mstate, r, en, c));
    @(posedge clk);
    mstate = exp_next(mstate, r, en, c);
  endtask

  task automatic async_clear();
    @(negedge clk);
    restart = 1'b0; enter = 1'b0;
    rst_n = 1'b0;
    #1;
    mstate = S_IDLE;
    check("R1", {open_w, error_w}, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [1:0] bad1, bad2;
    void'($urandom(32'd4242));
    bad1 = 2'd1; bad2 = 2'd3;
    repeat (2) @(posedge clk);
    #1;
    check("R1", {open_w, error_w}, 2'b00);
    @(negedge clk) rst_n = 1'b1;

    // R2 R4 plain success
    step("R2", 0, 1, N1);
    step("R4", 0, 1, N2);
    step("R4", 0, 0, bad1);
    step("R8", 0, 1, bad2);
    step("R4", 0, 0, 2'd0);
    step("R7", 1, 0, 2'd0);
    // R3 success with gaps
    step("R2", 0, 1, N1);
    for (int i = 0; i < 5; i++) step("R3", 0, 0, logic'(i[1:0]));
    step("R4", 0, 1, N2);
    step("R7", 1, 1, bad1);
    // R5 first wrong
    step("R5", 0, 1, bad1);
    step("R5", 0, 0, N1);
    step("R8", 0, 1, N1);
    step("R8", 0, 1, N2);
    step("R7", 1, 0, 2'd0);
    // R6 second wrong
    step("R2", 0, 1, N1);
    step("R6", 0, 1, bad2);
    step("R6", 0, 1, N2);
    step("R7", 1, 0, 2'd0);
    // both wrong
    step("R5", 0, 1, bad2);
    step("R8", 0, 1, bad1);
    step("R7", 1, 0, 2'd0);
    // restart after right first
    step("R2", 0, 1, N1);
    step("R7", 1, 0, 2'd0);
    step("R7", 0, 1, N2);
    step("R7", 1, 0, 2'd0);
    // restart after wrong first
    step("R5", 0, 1, bad1);
    step("R7", 1, 1, N1);
    step("R7", 0, 1, N1);
    step("R4", 0, 1, N2);
    // async clear from open
    async_clear();
    step("R1", 0, 1, N2);

    for (int i = 0; i < 3000; i++) begin
      bit r, en;
      logic [1:0] c;
      r  = ($urandom_range(0, 15) == 0);
      en = ($urandom_range(0, 2) == 0);
      c  = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 199) == 0) async_clear();
      else step("R9", r, en, c);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule